// File: doc/BRIEF.md
# Background Self-Calibration Sequencer

This block is the control sequencer for the digital section of a delta-sigma converter while it runs in its continuous self-calibration mode. While that mode is selected, it steps through a fixed period of six conversion slots and moves forward once for each conversion-complete strobe. The first slot shorts the sampler input and starts an offset calibration. The next three slots switch the sampler across the reference input for a gain calibration. The last two slots reconnect the analog input so that the decimation filter refills. Calibration therefore runs alongside normal conversion and never halts it.

The sequencer presents only one result in every six conversion slots as valid. It does this with an active-low data-ready output, which goes low in the shorted-input slot once a complete pass has filled the filter. When the mode field takes a different code, the sequencer lets the conversion in progress finish. It then drops back to idle with the sampler on the analog input. The sampler, the modulator, the filter arithmetic and the coefficient math are not part of this block. They connect to it only through the strobe and the select lines.

Top module: `bgcal_seq`

## Requirements
- R1: After reset the sequencer is idle: seqActive is 0, samplerSel is 2'b00 (analog input), dataReadyN is 1, and both calibration start pulses are 0.
- R2: An idle sequencer starts only when convDone is high and modeCode equals the background-calibration code (default 3'b101). A strobe under any other code leaves it idle. With no strobe, the matching code alone does not start it.
- R3: Slot 0 is the offset slot. samplerSel is 2'b10 (shorted input), and offsetCalStart pulses in the clock after the strobe that enters the slot.
- R4: Slots 1 to 3 are the gain slots. samplerSel is 2'b01 (reference), and gainCalStart pulses in the clock after the strobe that enters slot 1.
- R5: Slots 4 and 5 are the refill slots. samplerSel is 2'b00 (analog input) and dataReadyN stays 1.
- R6: dataReadyN is 0 only in slot 0, and only after a full six-slot pass has completed. That gives one valid result per six strobes and none on the first pass after entry.
- R7: The slot position, samplerSel and dataReadyN change only on a clock where convDone is high.
- R8: When modeCode leaves the background code in the middle of a period, the outputs of the current slot hold until the next strobe. On that strobe the block goes idle (samplerSel 2'b00, dataReadyN 1, seqActive 0). A later re-entry begins a fresh, unprimed pass.
- R9: Each calibration start pulse lasts exactly one clock, and the two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeCode | input | 3 | Operating-mode field |
| convDone | input | 1 | Conversion-complete strobe, one clock wide |
| samplerSel | output | 2 | Sampler source: 00 analog, 01 reference, 10 shorted |
| offsetCalStart | output | 1 | One-clock pulse that starts an offset calibration |
| gainCalStart | output | 1 | One-clock pulse that starts a gain calibration |
| dataReadyN | output | 1 | Active-low valid-data flag |
| seqActive | output | 1 | High while the calibration sequence is running |

## Verification
The assertions check on every cycle that the slot state holds between strobes and that each calibration pulse is one clock wide, with the two never overlapping. They also check that each pulse lines up with its own slot, that data-ready is only low while the input is shorted, and that a strobe under a foreign mode code ends the run. The bench scenarios cover what needs a history: the mode code is swept at the idle gate, and the slot pattern is followed over four full periods to count exactly one valid flag per six strobes. They also show that the first pass stays unflagged, that a mid-period exit holds its slot until the next strobe, and that re-entry starts unprimed.

// File: rtl/bgcal_pkg.sv
package bgcal_pkg;

  typedef enum logic [1:0] {
    SEL_ANALOG = 2'b00,
    SEL_REF    = 2'b01,
    SEL_SHORT  = 2'b10
  } samplerSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic running;
    logic startSeq;
    logic stepSeq;
    logic stopSeq;
  } seqCtrl_t;

endpackage

// File: rtl/bgcal_ctrl.sv
module bgcal_ctrl
  import bgcal_pkg::*;
#(
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] BG_CODE = 3'b101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeCode,
  input  logic              convDone,
  output seqCtrl_t          ctrl
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t state;
  logic       modeOk;

  assign modeOk = (modeCode == BG_CODE);

  always_comb begin
    ctrl          = '0;
    ctrl.running  = (state == ST_RUN);
    ctrl.startSeq = (state == ST_IDLE) && convDone && modeOk;
    ctrl.stepSeq  = (state == ST_RUN) && convDone && modeOk;
    ctrl.stopSeq  = (state == ST_RUN) && convDone && !modeOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (ctrl.startSeq) begin
      state <= ST_RUN;
    end else if (ctrl.stopSeq) begin
      state <= ST_IDLE;
    end
  end

  // R8: a strobe under a foreign code ends the run
  assert_exit_on_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && convDone && !modeOk) |=> (state == ST_IDLE));

  // R2: idle never leaves without a strobe
  assert_idle_wait_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !convDone) |=> (state == ST_IDLE));

endmodule

// File: rtl/bgcal_datapath.sv
module bgcal_datapath
  import bgcal_pkg::*;
#(
  parameter int GAIN_SLOTS   = 3,
  parameter int REFILL_SLOTS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqCtrl_t    ctrl,
  output logic [1:0]  samplerSel,
  output logic        offsetCalStart,
  output logic        gainCalStart,
  output logic        dataReadyN
);

  localparam int PERIOD = 1 + GAIN_SLOTS + REFILL_SLOTS;
  localparam int SLOT_W = $clog2(PERIOD);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PERIOD - 1);
  localparam logic [SLOT_W-1:0] GAIN_END  = SLOT_W'(GAIN_SLOTS);

  logic [SLOT_W-1:0] slot;
  logic              primed;
  logic              anyStrobe;
  samplerSel_t       selNext;

  assign anyStrobe = ctrl.startSeq | ctrl.stepSeq | ctrl.stopSeq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot           <= '0;
      primed         <= 1'b0;
      offsetCalStart <= 1'b0;
      gainCalStart   <= 1'b0;
    end else begin
      offsetCalStart <= 1'b0;
      gainCalStart   <= 1'b0;
      if (ctrl.startSeq) begin
        slot           <= '0;
        primed         <= 1'b0;
        offsetCalStart <= 1'b1;
      end else if (ctrl.stopSeq) begin
        slot   <= '0;
        primed <= 1'b0;
      end else if (ctrl.stepSeq) begin
        if (slot == LAST_SLOT) begin
          slot           <= '0;
          primed         <= 1'b1;
          offsetCalStart <= 1'b1;
        end else begin
          slot <= slot + 1'b1;
          if (slot == '0) gainCalStart <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!ctrl.running)        selNext = SEL_ANALOG;
    else if (slot == '0)      selNext = SEL_SHORT;
    else if (slot <= GAIN_END) selNext = SEL_REF;
    else                      selNext = SEL_ANALOG;
  end

  assign samplerSel = selNext;
  assign dataReadyN = !(ctrl.running && primed && slot == '0);

  // R7: slot state only moves on a strobe
  assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    !anyStrobe |=> ($stable(slot) && $stable(primed)));

  // R9: pulses one clock wide, never together
  assert_offset_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    offsetCalStart |=> !offsetCalStart);
  assert_gain_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    gainCalStart |=> !gainCalStart);
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(offsetCalStart && gainCalStart));

  // R3 / R4: pulses line up with their slot
  assert_offset_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    offsetCalStart |-> (ctrl.running && slot == '0));
  assert_gain_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    gainCalStart |-> (ctrl.running && slot == SLOT_W'(1)));

  // R6: valid flag only while input is shorted
  assert_ready_shorted_R6: assert property (@(posedge clk) disable iff (!rstN)
    !dataReadyN |-> (samplerSel == SEL_SHORT));

endmodule

// File: rtl/bgcal_seq.sv
module bgcal_seq
  import bgcal_pkg::*;
#(
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] BG_CODE = 3'b101,
  parameter int GAIN_SLOTS   = 3,
  parameter int REFILL_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeCode,
  input  logic              convDone,
  output logic [1:0]        samplerSel,
  output logic              offsetCalStart,
  output logic              gainCalStart,
  output logic              dataReadyN,
  output logic              seqActive
);

  seqCtrl_t ctrl;

  bgcal_ctrl #(
    .MODE_W (MODE_W),
    .BG_CODE(BG_CODE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeCode(modeCode),
    .convDone(convDone),
    .ctrl    (ctrl)
  );

  bgcal_datapath #(
    .GAIN_SLOTS  (GAIN_SLOTS),
    .REFILL_SLOTS(REFILL_SLOTS)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .samplerSel    (samplerSel),
    .offsetCalStart(offsetCalStart),
    .gainCalStart  (gainCalStart),
    .dataReadyN    (dataReadyN)
  );

  assign seqActive = ctrl.running;

endmodule

// File: tb/bgcal_seq_bench.sv
module bgcal_seq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeCode = 3'b000;
  logic       convDone = 1'b0;
  logic [1:0] samplerSel;
  logic       offsetCalStart, gainCalStart, dataReadyN, seqActive;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int readyLows = 0;

  always #5 clk = ~clk;

  bgcal_seq u_bgcal_seq (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .convDone(convDone),
    .samplerSel(samplerSel), .offsetCalStart(offsetCalStart),
    .gainCalStart(gainCalStart), .dataReadyN(dataReadyN), .seqActive(seqActive)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) convDone = 1'b1;
    @(negedge clk) convDone = 1'b0;
  endtask

  task automatic chkIdle(input string tag);
    chk({tag, " sel"}, samplerSel, 0);
    chk({tag, " readyN"}, dataReadyN, 1);
    chk({tag, " active"}, seqActive, 0);
    chk({tag, " pulses"}, {offsetCalStart, gainCalStart}, 0);
  endtask

  // expected outputs after k strobes since entry (k >= 1)
  task automatic chkSlot(input int k);
    int s;
    int expSel;
    s = (k - 1) % 6;
    expSel = (s == 0) ? 2 : ((s <= 3) ? 1 : 0);
    chk($sformatf("R3 R4 R5 sel k=%0d", k), samplerSel, expSel);
    chk($sformatf("R6 readyN k=%0d", k), dataReadyN, (s == 0 && k > 1) ? 0 : 1);
    chk($sformatf("R3 offset pulse k=%0d", k), offsetCalStart, (s == 0) ? 1 : 0);
    chk($sformatf("R4 gain pulse k=%0d", k), gainCalStart, (s == 1) ? 1 : 0);
    chk($sformatf("R2 active k=%0d", k), seqActive, 1);
    if (!dataReadyN) readyLows++;
    @(negedge clk);
    chk($sformatf("R9 pulses clear k=%0d", k), {offsetCalStart, gainCalStart}, 0);
    chk($sformatf("R7 sel held k=%0d", k), samplerSel, expSel);
    chk($sformatf("R7 readyN held k=%0d", k), dataReadyN, (s == 0 && k > 1) ? 0 : 1);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chkIdle("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1 after release");

    // R2: every foreign code leaves idle on a strobe
    for (int c = 0; c < 8; c++) begin
      if (c == 5) continue;
      modeCode = 3'(c);
      strobe();
      chkIdle($sformatf("R2 code=%0d", c));
    end

    // R2: correct code without a strobe does nothing
    modeCode = 3'b101;
    repeat (5) @(negedge clk);
    chkIdle("R2 no strobe");

    // four full periods
    for (int k = 1; k <= 24; k++) begin
      strobe();
      chkSlot(k);
    end
    chk("R6 valid flags in 24 strobes", readyLows, 3);

    // advance to slot 2 (gain), then leave the mode
    for (int k = 25; k <= 27; k++) begin
      strobe();
      chkSlot(k);
    end
    modeCode = 3'b001;
    repeat (3) @(negedge clk);
    chk("R8 slot held sel", samplerSel, 1);
    chk("R8 slot held active", seqActive, 1);
    strobe();
    chkIdle("R8 exit");

    // re-entry is unprimed
    modeCode = 3'b101;
    readyLows = 0;
    for (int k = 1; k <= 7; k++) begin
      strobe();
      chkSlot(k);
    end
    chk("R8 reentry single valid flag", readyLows, 1);

    finishRun();
  end

endmodule